// File: doc/BRIEF.md
# Dual-Output Interrupt Aggregator

This block gathers interrupt requests for a peripheral bus unit into one shared status register and drives two upstream interrupt lines from it. Hardware event inputs set status bits. Software acknowledges a source by writing a one to its status bit. Each output line has its own enable mask: one mask feeds the normal line and the other feeds the non-recoverable-host line. Two write-only trigger locations let software raise user interrupt bits. Each trigger comes with four 32-bit scratch words that the hardware never interprets.

A parameter selects between two variants. The default variant has the second mask at 0x144 and drives both lines. The GPIO variant places a GPIO status/enable pair at 0x104/0x144 instead. That pair works as extra bits of the main status and enable registers, and the non-recoverable-host line is held low. Software reaches the block through a single-cycle register port: a write strobe, a byte address and write data, with read data that follows the address combinationally.

Top module: `bus_irq_hub`

## Requirements
- R1: After reset, every status, enable, mask and scratch register reads zero and both interrupt lines are low.
- R2: A write to 0x100 clears exactly the status bits that are one in the written data; status bits written as zero keep their value. Status layout: bits 0..N_HW-1 are hardware events (N_HW=8 by default), bit N_HW is USER0, bit N_HW+1 is USER1, and the bits above those read zero.
- R3: If a hardware event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R4: The normal line goes high exactly one clock after any status bit is both set and enabled in the 0x140 enable register (same layout as status). It goes low one clock after no such bit remains.
- R5: The non-recoverable-host line follows the mask at 0x144 with the same one-clock timing. The USER1 bit of that mask does not exist: it reads zero and cannot enable the line.
- R6: A write of any data value, including zero, to 0x150 sets USER0. A write of any data value to 0x170 sets USER1.
- R7: Reads of 0x150 and 0x170 return zero.
- R8: Scratch words at 0x154+4*i and 0x174+4*i (i = 0..3) hold the written 32-bit values. Writing them has no effect on status or on either line.
- R9: In the GPIO variant, 0x104 is a GPIO status register that gpio_evt_i sets and that is cleared by writing ones. 0x144 is its enable. The enabled GPIO bits drive the normal line with the R4 timing, and the non-recoverable-host line stays low.
- R10: Reads of addresses that are not mapped return zero. This includes 0x104 in the default variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | ADDR_W (12) | Byte address of the register access |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i (combinational) |
| hw_evt_i | input | N_HW (8) | Hardware event requests, one per status bit; a high cycle sets the bit |
| gpio_evt_i | input | N_GPIO (4) | GPIO change requests, used only in the GPIO variant |
| irq_o | output | 1 | Normal upstream interrupt line, registered |
| irq_nrh_o | output | 1 | Non-recoverable-host interrupt line, registered |

## Verification
The bench aims at four races and edges:

- **Event racing a clear.** The bench sets and clears the same status bit in one cycle. A design that let the clear win would lose an interrupt and show the bit as zero.
- **Output timing.** The bench samples each line in the cycle before it should change and in the cycle after. A combinational line would be caught high one cycle early, and a line with two register stages would be caught low one cycle late.
- **Missing USER1 mask bit.** The bench writes all ones to the second mask and then raises USER1 alone. A design that kept that mask bit would fire the non-recoverable-host line.
- **Trigger and scratch decode.** The bench writes zero data to a trigger, reads the triggers back, and exercises the scratch words at both ends of each bank. A design that tested the data value, returned stored data from a trigger, or mis-decoded the scratch bounds would miss the trigger, read back a nonzero value, or corrupt a neighbouring word.

// File: rtl/bus_irq_pkg.sv
package bus_irq_pkg;
   // register offsets (byte addresses inside the block's window)
   localparam logic [15:0] OFS_STAT     = 16'h0100;
   localparam logic [15:0] OFS_GSTAT    = 16'h0104;
   localparam logic [15:0] OFS_EN       = 16'h0140;
   localparam logic [15:0] OFS_MASK2    = 16'h0144;
   localparam logic [15:0] OFS_TRIG0    = 16'h0150;
   localparam logic [15:0] OFS_SCR0     = 16'h0154;
   localparam logic [15:0] OFS_TRIG1    = 16'h0170;
   localparam logic [15:0] OFS_SCR1     = 16'h0174;
   localparam int unsigned SCR_WORDS    = 4;

   typedef enum logic [0:0] {
      VAR_DUAL = 1'b0,
      VAR_GPIO = 1'b1
   } hub_variant_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   initial begin
      if (W < 1) $error("irq_status_reg: W must be at least 1");
   end

   logic [W-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_i) | set_i;
   end

   assign stat_o = stat_q;

   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)))
      else $error("event lost"); // R3

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0))
      else $error("clear ignored"); // R2
endmodule

// File: rtl/irq_scratch_bank.sv
module irq_scratch_bank #(
   parameter int unsigned DW    = 32,
   parameter int unsigned WORDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [$clog2(WORDS)-1:0] idx_i,
   input  logic [DW-1:0]            wdata_i,
   output logic [DW-1:0]            rdata_o
);
   localparam int unsigned IW = $clog2(WORDS);

   initial begin
      if (WORDS < 2) $error("irq_scratch_bank: WORDS must be at least 2");
   end

   logic [DW-1:0] word_q [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           word_q[g] <= '0;
         else if (wr_i && idx_i == IW'(g))     word_q[g] <= wdata_i;
      end
   end

   assign rdata_o = word_q[idx_i];
endmodule

// File: rtl/irq_line.sv
module irq_line #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend_i,
   input  logic [W-1:0] en_i,
   output logic         line_o
);
   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= |(pend_i & en_i);
   end

   assign line_o = line_q;
endmodule

// File: rtl/bus_irq_hub.sv
module bus_irq_hub
   import bus_irq_pkg::*;
#(
   parameter int unsigned  ADDR_W  = 12,
   parameter int unsigned  DATA_W  = 32,
   parameter int unsigned  N_HW    = 8,
   parameter int unsigned  N_GPIO  = 4,
   parameter hub_variant_e VARIANT = VAR_DUAL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [N_HW-1:0]   hw_evt_i,
   input  logic [N_GPIO-1:0] gpio_evt_i,
   output logic              irq_o,
   output logic              irq_nrh_o
);
   localparam int unsigned SW   = N_HW + 2;
   localparam int unsigned U0   = N_HW;
   localparam int unsigned U1   = N_HW + 1;
   localparam int unsigned SIW  = $clog2(SCR_WORDS);
   localparam int unsigned LW   = SW + N_GPIO;

   initial begin
      if (ADDR_W > 16 || ADDR_W < 10) $error("bus_irq_hub: ADDR_W must be 10..16");
      if (SW > DATA_W)                $error("bus_irq_hub: status does not fit data width");
      if (N_GPIO > DATA_W || N_GPIO < 1) $error("bus_irq_hub: bad N_GPIO");
      if (DATA_W < 32)                $error("bus_irq_hub: scratch words need 32 bits");
   end

   // ---------------- decode ----------------
   logic [15:0] a16;
   assign a16 = 16'(addr_i);

   logic hit_stat, hit_gstat, hit_en, hit_m2, hit_t0, hit_t1;
   assign hit_stat  = (a16 == OFS_STAT);
   assign hit_gstat = (a16 == OFS_GSTAT);
   assign hit_en    = (a16 == OFS_EN);
   assign hit_m2    = (a16 == OFS_MASK2);
   assign hit_t0    = (a16 == OFS_TRIG0);
   assign hit_t1    = (a16 == OFS_TRIG1);

   logic [15:0] off0, off1;
   logic        hit_s0, hit_s1;
   assign off0   = a16 - OFS_SCR0;
   assign off1   = a16 - OFS_SCR1;
   assign hit_s0 = (off0 < 16'(4 * SCR_WORDS)) && (off0[1:0] == 2'b00);
   assign hit_s1 = (off1 < 16'(4 * SCR_WORDS)) && (off1[1:0] == 2'b00);

   // ---------------- main status ----------------
   logic [SW-1:0] stat, stat_set, stat_clr;
   assign stat_set = {wr_en_i && hit_t1, wr_en_i && hit_t0, hw_evt_i};
   assign stat_clr = (wr_en_i && hit_stat) ? wdata_i[SW-1:0] : '0;

   irq_status_reg #(.W(SW)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .set_i(stat_set), .clr_i(stat_clr), .stat_o(stat)
   );

   // ---------------- normal enable ----------------
   logic [SW-1:0] en_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  en_q <= '0;
      else if (wr_en_i && hit_en)  en_q <= wdata_i[SW-1:0];
   end

   // ---------------- variant-specific registers ----------------
   logic [N_GPIO-1:0] gstat, gen;
   logic [SW-1:0]     mask2;

   if (VARIANT == VAR_GPIO) begin : g_gpio
      logic [N_GPIO-1:0] gclr;
      logic [N_GPIO-1:0] gen_q;
      assign gclr = (wr_en_i && hit_gstat) ? wdata_i[N_GPIO-1:0] : '0;

      irq_status_reg #(.W(N_GPIO)) u_gstat (
         .clk(clk), .rst_n(rst_n),
         .set_i(gpio_evt_i), .clr_i(gclr), .stat_o(gstat)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  gen_q <= '0;
         else if (wr_en_i && hit_m2)  gen_q <= wdata_i[N_GPIO-1:0];
      end
      assign gen   = gen_q;
      assign mask2 = '0;
   end else begin : g_dual
      logic [SW-1:0] m2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  m2_q <= '0;
         else if (wr_en_i && hit_m2)  m2_q <= wdata_i[SW-1:0] & ~(SW'(1) << U1);
      end
      assign mask2 = m2_q;
      assign gstat = '0;
      assign gen   = '0;
   end

   // ---------------- scratch banks ----------------
   logic [DATA_W-1:0] scr_rd [2];
   logic [SIW-1:0]    scr_idx [2];
   logic              scr_hit [2];
   assign scr_idx[0] = off0[SIW+1:2];
   assign scr_idx[1] = off1[SIW+1:2];
   assign scr_hit[0] = hit_s0;
   assign scr_hit[1] = hit_s1;

   for (genvar b = 0; b < 2; b++) begin : g_scr
      irq_scratch_bank #(.DW(DATA_W), .WORDS(SCR_WORDS)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_i(wr_en_i && scr_hit[b]), .idx_i(scr_idx[b]),
         .wdata_i(wdata_i), .rdata_o(scr_rd[b])
      );
   end

   // ---------------- output lines ----------------
   irq_line #(.W(LW)) u_line_norm (
      .clk(clk), .rst_n(rst_n),
      .pend_i({gstat, stat}), .en_i({gen, en_q}), .line_o(irq_o)
   );

   irq_line #(.W(SW)) u_line_nrh (
      .clk(clk), .rst_n(rst_n),
      .pend_i(stat), .en_i(mask2), .line_o(irq_nrh_o)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rdata_o = '0;
      if (hit_stat)                                rdata_o = DATA_W'(stat);
      else if (hit_en)                             rdata_o = DATA_W'(en_q);
      else if (hit_gstat && VARIANT == VAR_GPIO)   rdata_o = DATA_W'(gstat);
      else if (hit_m2 && VARIANT == VAR_GPIO)      rdata_o = DATA_W'(gen);
      else if (hit_m2)                             rdata_o = DATA_W'(mask2);
      else if (hit_s0)                             rdata_o = scr_rd[0];
      else if (hit_s1)                             rdata_o = scr_rd[1];
   end

   // ---------------- assertions ----------------
   AST_TRIG0_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && hit_t0) |=> stat[U0])
      else $error("USER0 trigger missed"); // R6

   AST_TRIG1_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && hit_t1) |=> stat[U1])
      else $error("USER1 trigger missed"); // R6

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == '0 && gstat == '0) |=> !irq_o)
      else $error("normal line high with nothing pending"); // R4

   AST_NRH_NO_USER1: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == (SW'(1) << U1)) |=> !irq_nrh_o)
      else $error("USER1 reached second line"); // R5

   AST_TRIG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_t0 || hit_t1) |-> (rdata_o == '0))
      else $error("trigger read nonzero"); // R7
endmodule

// File: tb/tb_bus_irq_hub.sv
`timescale 1ns/1ps
module tb_bus_irq_hub;
   import bus_irq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_a = 1'b0, wr_b = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_a, rd_b;
   logic [7:0]  hw_evt = '0;
   logic [3:0]  gpio_evt = '0;
   logic        irq_a, nrh_a, irq_b, nrh_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bus_irq_hub #(.VARIANT(VAR_DUAL)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_a), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rd_a), .hw_evt_i(hw_evt), .gpio_evt_i(gpio_evt),
      .irq_o(irq_a), .irq_nrh_o(nrh_a)
   );

   bus_irq_hub #(.VARIANT(VAR_GPIO)) dut_g (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_b), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rd_b), .hw_evt_i(hw_evt), .gpio_evt_i(gpio_evt),
      .irq_o(irq_b), .irq_nrh_o(nrh_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit g, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d;
      if (g) wr_b = 1'b1; else wr_a = 1'b1;
      @(negedge clk);
      wr_a = 1'b0; wr_b = 1'b0;
   endtask

   task automatic rd(input bit g, input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #0.5;
      d = g ? rd_b : rd_a;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(0, 12'h100, v); chk("R1 status", v, 0);
      rd(0, 12'h140, v); chk("R1 enable", v, 0);
      rd(0, 12'h144, v); chk("R1 mask2", v, 0);
      rd(0, 12'h160, v); chk("R1 scratch", v, 0);
      rd(1, 12'h104, v); chk("R1 gpio status", v, 0);
      chk("R1 lines", {irq_a, nrh_a, irq_b, nrh_b}, 0);
   endtask

   task automatic t_event_line();
      logic [31:0] v;
      wr(0, 12'h140, 32'h8);
      @(negedge clk); hw_evt = 8'h09;
      @(negedge clk); hw_evt = 8'h00;
      chk("R4 line not yet high", irq_a, 0);
      @(negedge clk);
      chk("R4 line high one clock later", irq_a, 1);
      chk("R5 second line idle", nrh_a, 0);
      rd(0, 12'h100, v); chk("R2 status after events", v, 32'h09);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(0, 12'h100, 32'h1);
      rd(0, 12'h100, v); chk("R2 partial clear", v, 32'h08);
      chk("R4 line still high", irq_a, 1);
      @(negedge clk); addr = 12'h100; wdata = 32'h8; wr_a = 1'b1;
      @(negedge clk); wr_a = 1'b0;
      chk("R4 line falls one clock later, not yet", irq_a, 1);
      @(negedge clk);
      chk("R4 line low", irq_a, 0);
      rd(0, 12'h100, v); chk("R2 fully cleared", v, 0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      @(negedge clk);
      hw_evt = 8'h04; addr = 12'h100; wdata = 32'h06; wr_a = 1'b1;
      @(negedge clk);
      hw_evt = 8'h00; wr_a = 1'b0;
      rd(0, 12'h100, v); chk("R3 event beats clear", v, 32'h04);
      wr(0, 12'h100, 32'hFFFF_FFFF);
      rd(0, 12'h100, v); chk("R2 clear all", v, 0);
   endtask

   task automatic t_user();
      logic [31:0] v;
      wr(0, 12'h150, 32'h0);
      rd(0, 12'h100, v); chk("R6 USER0 with zero data", v, 32'h100);
      wr(0, 12'h170, 32'hFFFF);
      rd(0, 12'h100, v); chk("R6 USER1", v, 32'h300);
      rd(0, 12'h150, v); chk("R7 trigger0 reads zero", v, 0);
      rd(0, 12'h170, v); chk("R7 trigger1 reads zero", v, 0);
      wr(0, 12'h100, 32'h300);
      rd(0, 12'h100, v); chk("R2 user bits cleared", v, 0);
   endtask

   task automatic t_nrh();
      logic [31:0] v;
      wr(0, 12'h140, 32'h0);
      wr(0, 12'h144, 32'hFFFF_FFFF);
      rd(0, 12'h144, v); chk("R5 mask has no USER1 bit", v, 32'h0FF | 32'h100);
      wr(0, 12'h170, 32'h1);
      @(negedge clk); @(negedge clk);
      chk("R5 USER1 cannot drive second line", nrh_a, 0);
      chk("R4 normal line masked", irq_a, 0);
      @(negedge clk); addr = 12'h150; wr_a = 1'b1;
      @(negedge clk); wr_a = 1'b0;
      chk("R5 second line not yet", nrh_a, 0);
      @(negedge clk);
      chk("R5 second line high", nrh_a, 1);
      wr(0, 12'h100, 32'h300);
      wr(0, 12'h144, 32'h0);
      @(negedge clk);
      chk("R5 second line low after clear", nrh_a, 0);
   endtask

   task automatic t_scratch();
      logic [31:0] v;
      for (int i = 0; i < 4; i++) begin
         wr(0, 12'(12'h154 + 4 * i), 32'hA500_0000 + 32'(i));
         wr(0, 12'(12'h174 + 4 * i), 32'h5A00_0010 + 32'(i));
      end
      for (int i = 0; i < 4; i++) begin
         rd(0, 12'(12'h154 + 4 * i), v); chk("R8 bank0 word", v, 32'hA500_0000 + 32'(i));
         rd(0, 12'(12'h174 + 4 * i), v); chk("R8 bank1 word", v, 32'h5A00_0010 + 32'(i));
      end
      rd(0, 12'h100, v); chk("R8 status untouched", v, 0);
      @(negedge clk);
      chk("R8 lines untouched", {irq_a, nrh_a}, 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(0, 12'h104, v); chk("R10 gpio reg absent in dual", v, 0);
      rd(0, 12'h108, v); chk("R10 unmapped", v, 0);
      rd(0, 12'h184, v); chk("R10 past bank1", v, 0);
   endtask

   task automatic t_gpio();
      logic [31:0] v;
      @(negedge clk); gpio_evt = 4'h3;
      @(negedge clk); gpio_evt = 4'h0;
      rd(1, 12'h104, v); chk("R9 gpio status", v, 32'h3);
      @(negedge clk);
      chk("R9 gpio disabled, line low", irq_b, 0);
      @(negedge clk); addr = 12'h144; wdata = 32'h2; wr_b = 1'b1;
      @(negedge clk); wr_b = 1'b0;
      chk("R9 line not yet", irq_b, 0);
      @(negedge clk);
      chk("R9 gpio drives normal line", irq_b, 1);
      chk("R9 second line held low", nrh_b, 0);
      rd(1, 12'h144, v); chk("R9 gpio enable readback", v, 32'h2);
      wr(1, 12'h104, 32'h2);
      rd(1, 12'h104, v); chk("R9 gpio w1c", v, 32'h1);
      @(negedge clk);
      chk("R9 line low after gpio clear", irq_b, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_event_line();
      t_w1c();
      t_race();
      t_user();
      t_nrh();
      t_scratch();
      t_unmapped();
      t_gpio();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule